// File: doc/BRIEF.md
# Parallel Squaring and Peak Search

The block sits after a correlator that delivers its output as a frame of 1024 signed fixed-point samples, sixteen per clock. Every valid cycle it squares all sixteen lanes at once, drops the fractional bits of each product and keeps an 18-bit integer magnitude. The sixteen magnitudes of one cycle are packed into one wide word and written into an internal memory of 64 words, one word per input set, so a downstream stage can later fetch a whole set in a single read.

While the frame streams in, a pipelined pairwise comparison tree picks the largest magnitude of each set, and a final stage keeps the largest value seen so far in the frame. When the frame's last set has passed through, the block raises a one-cycle done pulse and presents the peak magnitude together with the memory word that holds it and the lane inside that word. Ties always resolve toward the earliest sample of the frame.

Top module: `sq_peak_search`

## Requirements
- R1: For an input lane value x (18-bit two's complement, 8 fractional bits, lane j at bits [18*j+17:18*j] of `in_data`), the stored magnitude is floor(x*x / 65536) as an unsigned 18-bit integer, placed at bits [18*j+17:18*j] of its memory word.
- R2: When floor(x*x / 65536) does not fit in 18 bits (only x = -131072), the stored magnitude saturates to 262143.
- R3: The k-th valid set of a frame (k counted from 0) is written to memory word k; `rd_data` shows the word addressed by `rd_addr` one cycle after the address is presented.
- R4: `pk_done` is high for exactly one cycle, five cycles after the cycle that carries the 64th valid set of a frame, and at no other time.
- R5: With `pk_done`, `pk_val` equals the largest stored magnitude of the frame, `pk_addr` its word and `pk_lane` its lane.
- R6: Equal maxima within one set report the lowest lane.
- R7: Equal maxima in different sets report the earliest set.
- R8: Each frame's search starts afresh: a frame whose peak is smaller than the previous frame's peak reports its own peak.
- R9: Cycles with `in_valid` low neither write the memory, advance the set count, nor affect the peak, whatever `in_data` carries.
- R10: After reset, `pk_done` is low and `pk_val`, `pk_addr`, `pk_lane` are zero.
- R11: Between done pulses `pk_val`, `pk_addr` and `pk_lane` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` as one set of the current frame |
| in_data | input | 288 | Sixteen signed samples, lane j at bits [18*j+17:18*j] |
| rd_addr | input | 6 | Word address for the downstream read |
| rd_data | output | 288 | Packed magnitudes of the addressed word, one cycle later |
| pk_done | output | 1 | One-cycle pulse: peak outputs valid for the finished frame |
| pk_val | output | 18 | Peak magnitude of the frame |
| pk_addr | output | 6 | Memory word holding the peak |
| pk_lane | output | 4 | Lane of the peak inside that word |

## Verification
The done pulse and the peak fields are due five cycles after the cycle that presents the last set, so the bench, after the last set, samples the outputs on each of the next six falling edges and expects the pulse on the fifth only, then re-reads the fields on the sixth to see them held. A memory word is due on `rd_data` one cycle after its address, so the readback presents addresses on successive falling edges and compares each word one edge after its address was driven. The magnitudes are swept over every one of the 2^18 input codes, one contiguous block of codes per frame, with every expected square and peak computed arithmetically in the bench.

// File: rtl/sqpk_pkg.sv
// Package: shared types for the parallel squaring and peak search block.
// Assumes nothing beyond a single clock domain.
package sqpk_pkg;

    // Frame position tag that travels beside a set through the compare tree.
    typedef struct packed {
        logic vld;    // a real set occupies this pipeline slot
        logic first;  // set 0 of the frame
        logic last;   // final set of the frame
    } sqpk_tag_t;

endpackage

// File: rtl/sqpk_square.sv
// Module: sqpk_square
// Squares one signed fixed-point lane and keeps the integer part of the
// product as an unsigned magnitude, saturating when it does not fit.
// Assumes IN_FRAC fractional input bits, so the product has 2*IN_FRAC.
module sqpk_square #(
    parameter int unsigned IN_W    = 18,
    parameter int unsigned IN_FRAC = 8,
    parameter int unsigned OUT_W   = 18
) (
    input  logic signed [IN_W-1:0] x,
    output logic        [OUT_W-1:0] y
);
    localparam int unsigned PROD_W = 2 * IN_W;
    localparam int unsigned SHIFT  = 2 * IN_FRAC;
    localparam int unsigned INT_W  = PROD_W - SHIFT;

    logic signed [PROD_W-1:0] prod;
    logic        [INT_W-1:0]  int_part;

    // Full-precision square; always non-negative.
    assign prod     = x * x;
    // Drop the fractional bits of the product.
    assign int_part = INT_W'($unsigned(prod) >> SHIFT);

    if (INT_W > OUT_W) begin : g_sat
        logic over;
        // Any set bit above the kept width means the magnitude overflows.
        assign over = |int_part[INT_W-1:OUT_W];
        assign y    = over ? {OUT_W{1'b1}} : int_part[OUT_W-1:0];
    end else begin : g_fit
        assign y = OUT_W'(int_part);
    end

endmodule

// File: rtl/sqpk_max_tree.sv
// Module: sqpk_max_tree
// Pipelined pairwise maximum over LANES packed magnitudes: one compare
// level per clock, log2(LANES) levels, a new set accepted every cycle.
// Nodes are kept in heap order so a left child always covers lower lanes;
// the right child wins only when strictly larger, giving lowest-lane ties.
// Assumes LANES is a power of two and at least two.
module sqpk_max_tree #(
    parameter int unsigned LANES = 16,
    parameter int unsigned OUT_W = 18,
    localparam int unsigned LANE_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*OUT_W-1:0] leaf_word,
    output logic [OUT_W-1:0]       root_val,
    output logic [LANE_W-1:0]      root_lane
);
    localparam int unsigned NODES = LANES - 1;
    localparam int unsigned ALL   = NODES + LANES;

    logic [OUT_W-1:0]  node_val  [NODES];
    logic [LANE_W-1:0] node_lane [NODES];
    logic [OUT_W-1:0]  nxt_val   [NODES];
    logic [LANE_W-1:0] nxt_lane  [NODES];
    logic [OUT_W-1:0]  all_val   [ALL];
    logic [LANE_W-1:0] all_lane  [ALL];

    // Gather registered nodes and combinational leaves into one heap view.
    always_comb begin
        for (int i = 0; i < NODES; i++) begin
            all_val[i]  = node_val[i];
            all_lane[i] = node_lane[i];
        end
        for (int j = 0; j < LANES; j++) begin
            all_val[NODES+j]  = leaf_word[j*OUT_W +: OUT_W];
            all_lane[NODES+j] = LANE_W'(j);
        end
    end

    // Compare each node's two children; right wins only on strictly greater.
    always_comb begin
        for (int i = 0; i < NODES; i++) begin
            if (all_val[2*i+2] > all_val[2*i+1]) begin
                nxt_val[i]  = all_val[2*i+2];
                nxt_lane[i] = all_lane[2*i+2];
            end else begin
                nxt_val[i]  = all_val[2*i+1];
                nxt_lane[i] = all_lane[2*i+1];
            end
        end
    end

    // Advance every compare level by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NODES; i++) begin
                node_val[i]  <= '0;
                node_lane[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NODES; i++) begin
                node_val[i]  <= nxt_val[i];
                node_lane[i] <= nxt_lane[i];
            end
        end
    end

    assign root_val  = node_val[0];
    assign root_lane = node_lane[0];

endmodule

// File: rtl/sqpk_frame_mem.sv
// Module: sqpk_frame_mem
// One-write, one-read memory holding one packed word per input set.
// Read is registered: data for an address appears one clock later.
// Assumes the writer never targets the same word twice in one frame.
module sqpk_frame_mem #(
    parameter int unsigned WORD_W = 288,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] store [DEPTH];

    // Write the incoming set word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Registered read for the downstream consumer.
    always_ff @(posedge clk) begin
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/sqpk_peak_track.sv
// Module: sqpk_peak_track
// Final stage: folds each set's local maximum into a running frame maximum
// and publishes the result with a one-cycle done pulse on the last set.
// The running value restarts on the first set; on equal values the value
// already held (an earlier set) is kept.
module sqpk_peak_track
    import sqpk_pkg::*;
#(
    parameter int unsigned OUT_W  = 18,
    parameter int unsigned LANE_W = 4,
    parameter int unsigned SET_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sqpk_tag_t         tag,
    input  logic [SET_W-1:0]  set_addr,
    input  logic [OUT_W-1:0]  loc_val,
    input  logic [LANE_W-1:0] loc_lane,
    output logic              pk_done,
    output logic [OUT_W-1:0]  pk_val,
    output logic [SET_W-1:0]  pk_addr,
    output logic [LANE_W-1:0] pk_lane
);
    logic [OUT_W-1:0]  run_val;
    logic [SET_W-1:0]  run_addr;
    logic [LANE_W-1:0] run_lane;
    logic [OUT_W-1:0]  cand_val;
    logic [SET_W-1:0]  cand_addr;
    logic [LANE_W-1:0] cand_lane;
    logic              take_new;

    // Choose between the held maximum and this set's local maximum.
    always_comb begin
        take_new = tag.first || (loc_val > run_val);
        if (take_new) begin
            cand_val  = loc_val;
            cand_addr = set_addr;
            cand_lane = loc_lane;
        end else begin
            cand_val  = run_val;
            cand_addr = run_addr;
            cand_lane = run_lane;
        end
    end

    // Update the running maximum on every real set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_val  <= '0;
            run_addr <= '0;
            run_lane <= '0;
        end else if (tag.vld) begin
            run_val  <= cand_val;
            run_addr <= cand_addr;
            run_lane <= cand_lane;
        end
    end

    // Publish the frame result and pulse done on the frame's last set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_done <= 1'b0;
            pk_val  <= '0;
            pk_addr <= '0;
            pk_lane <= '0;
        end else begin
            pk_done <= tag.vld && tag.last;
            if (tag.vld && tag.last) begin
                pk_val  <= cand_val;
                pk_addr <= cand_addr;
                pk_lane <= cand_lane;
            end
        end
    end

endmodule

// File: rtl/sq_peak_search.sv
// Module: sq_peak_search (top)
// Squares LANES correlation samples per valid cycle, stores each set as one
// packed word and reports the frame peak with word address and lane.
// Latency: done rises LEVELS+1 cycles after the cycle carrying the last set.
// Assumes LANES and SETS are powers of two, LANES >= 2, SETS >= 2.
module sq_peak_search
    import sqpk_pkg::*;
#(
    parameter int unsigned LANES   = 16,
    parameter int unsigned IN_W    = 18,
    parameter int unsigned IN_FRAC = 8,
    parameter int unsigned OUT_W   = 18,
    parameter int unsigned SETS    = 64,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned SET_W  = $clog2(SETS),
    localparam int unsigned WORD_W = LANES * OUT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*IN_W-1:0] in_data,
    input  logic [SET_W-1:0]      rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  pk_done,
    output logic [OUT_W-1:0]      pk_val,
    output logic [SET_W-1:0]      pk_addr,
    output logic [LANE_W-1:0]     pk_lane
);
    localparam int unsigned LEVELS = LANE_W;

    logic              wr_en;
    logic [SET_W-1:0]  set_cnt;
    logic [WORD_W-1:0] sq_word;
    logic [OUT_W-1:0]  loc_val;
    logic [LANE_W-1:0] loc_lane;
    sqpk_tag_t         tag_in;
    sqpk_tag_t         tag_pipe  [LEVELS];
    logic [SET_W-1:0]  addr_pipe [LEVELS];

    // A set is accepted only when qualified and out of reset.
    assign wr_en = in_valid && rst_n;

    // Count accepted sets; wraps to the next frame after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_cnt <= '0;
        end else if (wr_en) begin
            set_cnt <= (set_cnt == SET_W'(SETS - 1)) ? '0 : set_cnt + 1'b1;
        end
    end

    // One squaring unit per lane.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        sqpk_square #(
            .IN_W    (IN_W),
            .IN_FRAC (IN_FRAC),
            .OUT_W   (OUT_W)
        ) u_sq (
            .x (in_data[j*IN_W +: IN_W]),
            .y (sq_word[j*OUT_W +: OUT_W])
        );
    end

    sqpk_frame_mem #(
        .WORD_W (WORD_W),
        .DEPTH  (SETS)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (set_cnt),
        .wr_data (sq_word),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sqpk_max_tree #(
        .LANES (LANES),
        .OUT_W (OUT_W)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .leaf_word (sq_word),
        .root_val  (loc_val),
        .root_lane (loc_lane)
    );

    // Frame position of the set entering the tree this cycle.
    always_comb begin
        tag_in.vld   = wr_en;
        tag_in.first = (set_cnt == '0);
        tag_in.last  = (set_cnt == SET_W'(SETS - 1));
    end

    // Carry the tag and word address alongside the tree levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LEVELS; k++) begin
                tag_pipe[k]  <= '0;
                addr_pipe[k] <= '0;
            end
        end else begin
            tag_pipe[0]  <= tag_in;
            addr_pipe[0] <= set_cnt;
            for (int k = 1; k < LEVELS; k++) begin
                tag_pipe[k]  <= tag_pipe[k-1];
                addr_pipe[k] <= addr_pipe[k-1];
            end
        end
    end

    sqpk_peak_track #(
        .OUT_W  (OUT_W),
        .LANE_W (LANE_W),
        .SET_W  (SET_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag      (tag_pipe[LEVELS-1]),
        .set_addr (addr_pipe[LEVELS-1]),
        .loc_val  (loc_val),
        .loc_lane (loc_lane),
        .pk_done  (pk_done),
        .pk_val   (pk_val),
        .pk_addr  (pk_addr),
        .pk_lane  (pk_lane)
    );

endmodule

// File: rtl/sqpk_checker.sv
// Module: sqpk_checker
// Protocol checks for sq_peak_search, attached with bind below.
// Assumes frames are at least two sets long.
module sqpk_checker #(
    parameter int unsigned OUT_W  = 18,
    parameter int unsigned SET_W  = 6,
    parameter int unsigned LANE_W = 4,
    parameter int unsigned WORD_W = 288
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              pk_done,
    input logic [OUT_W-1:0]  pk_val,
    input logic [SET_W-1:0]  pk_addr,
    input logic [LANE_W-1:0] pk_lane,
    input logic [SET_W-1:0]  rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              mem_we,
    input logic [SET_W-1:0]  mem_waddr,
    input logic [WORD_W-1:0] mem_wdata
);
    // R4: done never lasts more than one cycle.
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pk_done |=> !pk_done);

    // R4: a done pulse follows an accepted set five cycles earlier.
    assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pk_done |-> $past(in_valid, 5));

    // R11: peak fields only move together with a done pulse.
    assert_peak_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_done |-> ($stable(pk_val) && $stable(pk_addr) && $stable(pk_lane)));

    // R3: a word written one cycle and addressed the next is read back intact.
    assert_mem_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_we) && (rd_addr == $past(mem_waddr)) &&
         !(mem_we && (mem_waddr == rd_addr)))
        |=> (rd_data == $past(mem_wdata, 2)));

endmodule

bind sq_peak_search sqpk_checker #(
    .OUT_W  (OUT_W),
    .SET_W  (SET_W),
    .LANE_W (LANE_W),
    .WORD_W (WORD_W)
) i_sqpk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pk_done   (pk_done),
    .pk_val    (pk_val),
    .pk_addr   (pk_addr),
    .pk_lane   (pk_lane),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .mem_we    (wr_en),
    .mem_waddr (set_cnt),
    .mem_wdata (sq_word)
);

// File: tb/test_sq_peak_search.sv
`timescale 1ns/1ps
// Bench for sq_peak_search: directed frames plus a sweep of all input codes.
module test_sq_peak_search;
    localparam int LN = 16;
    localparam int IW = 18;
    localparam int OW = 18;
    localparam int NS = 64;
    localparam int SATV = 262143;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [LN*IW-1:0] in_data;
    logic [5:0]       rd_addr;
    logic [LN*OW-1:0] rd_data;
    logic             pk_done;
    logic [OW-1:0]    pk_val;
    logic [5:0]       pk_addr;
    logic [3:0]       pk_lane;

    int checks = 0;
    int fails  = 0;
    int xin [NS][LN];
    int e_val, e_addr, e_lane;
    int unsigned lcg = 32'd12345;

    sq_peak_search i_sq_peak_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pk_done  (pk_done),
        .pk_val   (pk_val),
        .pk_addr  (pk_addr),
        .pk_lane  (pk_lane)
    );

    always #10 clk = ~clk;

    // Record one check; print a FAIL line when it does not hold.
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected magnitude: integer part of x*x/2^16, saturated to 18 bits.
    function automatic int sq_exp(input int x);
        longint p;
        longint ip;
        p  = longint'(x) * longint'(x);
        ip = p / 65536;
        if (ip > SATV) ip = SATV;
        return int'(ip);
    endfunction

    // Expected peak: scan in sample order, replace only on strictly greater.
    task automatic calc_peak();
        e_val = -1; e_addr = 0; e_lane = 0;
        for (int s = 0; s < NS; s++)
            for (int l = 0; l < LN; l++)
                if (sq_exp(xin[s][l]) > e_val) begin
                    e_val = sq_exp(xin[s][l]); e_addr = s; e_lane = l;
                end
    endtask

    // Drive one frame; optionally insert idle cycles carrying decoy data.
    task automatic send_frame(input bit gaps);
        calc_peak();
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int l = 0; l < LN; l++) in_data[l*IW +: IW] = IW'(xin[s][l]);
            if (gaps && (s % 5 == 2)) begin
                @(negedge clk);
                in_valid = 1'b0;
                // R9: decoy would be the largest magnitude if it were taken
                for (int l = 0; l < LN; l++) in_data[l*IW +: IW] = 18'h20000;
            end
        end
        // R4/R5/R11: done due on the fifth falling edge after the last set
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) in_valid = 1'b0;
            chk(pk_done == (i == 5), "R4", "done timing", pk_done, (i == 5));
            if (i == 5 || i == 6) begin
                chk(pk_val == OW'(e_val), "R5", "peak value", pk_val, e_val);
                chk(pk_addr == 6'(e_addr), "R5", "peak word", pk_addr, e_addr);
                chk(pk_lane == 4'(e_lane), "R5", "peak lane", pk_lane, e_lane);
            end
        end
    endtask

    // Read every word back and compare all lanes (R1, R2, R3, R9).
    task automatic read_back();
        for (int a = 0; a <= NS; a++) begin
            @(negedge clk);
            if (a > 0) begin
                bit ok = 1'b1;
                int bad_l = 0;
                for (int l = LN - 1; l >= 0; l--)
                    if (int'(rd_data[l*OW +: OW]) != sq_exp(xin[a-1][l])) begin
                        ok = 1'b0; bad_l = l;
                    end
                chk(ok, (xin[a-1][bad_l] == -131072) ? "R2" : "R1/R3",
                    $sformatf("word %0d lane %0d", a - 1, bad_l),
                    rd_data[bad_l*OW +: OW], sq_exp(xin[a-1][bad_l]));
            end
            if (a < NS) rd_addr = 6'(a);
        end
    endtask

    task automatic fill_const(input int v);
        for (int s = 0; s < NS; s++)
            for (int l = 0; l < LN; l++) xin[s][l] = v;
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(pk_done == 1'b0, "R10", "done after reset", pk_done, 0);
        chk(pk_val == '0, "R10", "value after reset", pk_val, 0);
        chk(pk_addr == '0, "R10", "word after reset", pk_addr, 0);
        chk(pk_lane == '0, "R10", "lane after reset", pk_lane, 0);

        // Pseudo-random frame with idle gaps (R9)
        for (int s = 0; s < NS; s++)
            for (int l = 0; l < LN; l++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                xin[s][l] = int'(lcg[30:13]);
                if (xin[s][l] >= 131072) xin[s][l] -= 262144;
                if (xin[s][l] == -131072) xin[s][l] = 5;
            end
        send_frame(1'b1);
        read_back();
        // R11: fields still held long after the pulse
        chk(pk_val == OW'(e_val), "R11", "held value", pk_val, e_val);
        chk(pk_done == 1'b0, "R11", "no stray done", pk_done, 0);

        // Sweep of every 18-bit input code, 1024 codes per frame (R1, R2)
        for (int f = 0; f < 256; f++) begin
            for (int s = 0; s < NS; s++)
                for (int l = 0; l < LN; l++) begin
                    xin[s][l] = f * 1024 + s * 16 + l;
                    if (xin[s][l] >= 131072) xin[s][l] -= 262144;
                end
            send_frame(1'b0);
            read_back();
        end

        // R6: equal maxima in one set report the lower lane
        fill_const(0);
        xin[5][9] = 1000; xin[5][3] = -1000;
        send_frame(1'b0);
        chk(pk_lane == 4'd3, "R6", "lowest lane on tie", pk_lane, 3);

        // Large frame followed by an all-zero frame (R8)
        fill_const(131071);
        send_frame(1'b0);
        fill_const(0);
        send_frame(1'b0);
        chk(pk_val == '0, "R8", "fresh frame peak", pk_val, 0);
        read_back();

        // R7: equal maxima in two sets report the earlier set
        fill_const(7);
        xin[40][2] = 5000; xin[10][7] = -5000;
        send_frame(1'b0);
        chk(pk_addr == 6'd10, "R7", "earliest set on tie", pk_addr, 10);
        chk(pk_lane == 4'd7, "R7", "lane of earliest set", pk_lane, 7);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule